// File: doc/BRIEF.md
# Operand Address Generator

This unit forms the 15-bit operand address for a small 8-bit processor. The processor's 32K byte space is four 8K pages. The decoder hands the unit one request. The request carries the addressing form, the instruction's address or displacement field, the address of the current instruction, and the value of the index register that the instruction names. The unit returns the operand address and the value the index register should hold afterwards.

Two forms need no memory access:

- Relative requests add a signed 7-bit displacement to the current address. The sum wraps inside the current page.
- Absolute requests use the 15-bit field, optionally plus an index that may first be stepped up or down by one.

Indirect requests are different. They read a two-byte pointer through a single-outstanding memory read port and use that pointer as the operand address. When indexing is also selected, the index is added to the fetched pointer and not to the field.

Requests arrive on a valid/ready port. `req_ready` is high whenever no pointer fetch is in progress, and a request is taken only in a cycle where both `req_valid` and `req_ready` are high. On the memory side, the unit holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. It then waits, for any number of cycles, for a one-cycle `mem_rsp_valid` carrying the byte. The result is a plain one-cycle strobe, `res_valid`, with `res_addr` and `res_index` valid in that same cycle.

Top module: `opaddr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: With `req_rel`=1, the address keeps bits 14:13 of `req_pc`. Its bits 12:0 are `req_pc[12:0]` plus `req_field[6:0]` sign-extended, modulo 8192. `req_field[14:7]` has no effect.
- R3: With `req_rel`=0 and `req_ix`=00, the address equals `req_field`.
- R4: With `req_rel`=0 and `req_ix`=01, the address is `req_field` plus `req_index` as an unsigned value, modulo 32768. `res_index` equals `req_index`.
- R5: With `req_rel`=0 and `req_ix`=10 (or 11), the index is first incremented (or decremented) modulo 256. The address is `req_field` plus that new index, and `res_index` returns the new index.
- R6: With `req_rel`=1, `req_ix` is ignored: `res_index` equals `req_index` and no index enters the address.
- R7: With `req_ind`=1, the unit reads the byte at the computed address first, then the byte at that address plus 1. The address is {high byte bits 6:0, low byte}.
- R8: With `req_ind`=1 and `req_rel`=0 and `req_ix`≠00, the pointer is read at `req_field`, un-indexed. The (pre-modified) index is added to the fetched pointer, modulo 32768.
- R9: `res_valid` is high for exactly one cycle per request. For direct requests it is the cycle after acceptance. For indirect requests it is the cycle after the low byte's `mem_rsp_valid`.
- R10: `req_ready` is 0 from the cycle after an indirect request is accepted until its result cycle. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` stay unchanged.
- R11: In the cycle where `res_valid` is high, `req_ready` is 1, so the next request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_rel | input | 1 | 1 = relative form, 0 = absolute form |
| req_ind | input | 1 | 1 = fetch a pointer indirectly |
| req_ix | input | 2 | Index use: 00 none, 01 plain, 10 pre-increment, 11 pre-decrement |
| req_field | input | 15 | Absolute address, or displacement in bits 6:0 |
| req_pc | input | 15 | Address of the current instruction |
| req_index | input | 8 | Current value of the selected index register |
| mem_req_valid | output | 1 | Pointer byte read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 15 | Address of the pointer byte |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | 8 | Read data |
| res_valid | output | 1 | One-cycle result strobe |
| res_addr | output | 15 | Operand address |
| res_index | output | 8 | Index register value to write back |

## Verification
The two functions that share a cycle are the result strobe of one request and the acceptance of the next. The bench provokes this by driving a fresh request in the same cycle that `res_valid` of a direct request appears. It runs chains of back-to-back direct requests, and direct requests issued right after an indirect one completes.

It judges the overlap in three ways:
- it checks that `req_ready` is high in that strobe cycle;
- it checks that the following strobe lands one cycle later;
- a scoreboard confirms that each strobe's address and index belong to its own request and not to a neighbour.

Pointer reads are run with a stalling memory and varying response delays. Every read address is compared in order.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int PAGE_W = 2;
  localparam int OFS_W  = 13;
  localparam int BYTE_W = 8;
  localparam int DISP_W = 7;

  typedef enum logic [1:0] {
    IX_NONE  = 2'b00,
    IX_PLAIN = 2'b01,
    IX_INC   = 2'b10,
    IX_DEC   = 2'b11
  } ix_op_e;

  typedef enum logic [2:0] {
    F_IDLE   = 3'd0,
    F_HI_REQ = 3'd1,
    F_HI_RSP = 3'd2,
    F_LO_REQ = 3'd3,
    F_LO_RSP = 3'd4
  } fetch_st_e;
endpackage

// File: rtl/opaddr_index_step.sv
module opaddr_index_step
  import opaddr_pkg::*;
#(
  parameter int BYTE_W = opaddr_pkg::BYTE_W
) (
  input  logic              is_abs,
  input  logic [1:0]        op,
  input  logic [BYTE_W-1:0] idx_in,
  output logic              use_ix,
  output logic [BYTE_W-1:0] idx_out
);
  // Index only participates in absolute forms; relative leaves it untouched.
  always_comb begin
    use_ix  = is_abs && (op != IX_NONE);
    idx_out = idx_in;
    if (is_abs) begin
      unique case (op)
        IX_INC:  idx_out = idx_in + BYTE_W'(1);
        IX_DEC:  idx_out = idx_in - BYTE_W'(1);
        default: idx_out = idx_in;
      endcase
    end
  end
endmodule

// File: rtl/opaddr_base.sv
module opaddr_base #(
  parameter int PAGE_W = opaddr_pkg::PAGE_W,
  parameter int OFS_W  = opaddr_pkg::OFS_W,
  parameter int DISP_W = opaddr_pkg::DISP_W
) (
  input  logic                    rel,
  input  logic [PAGE_W+OFS_W-1:0] field,
  input  logic [PAGE_W+OFS_W-1:0] pc,
  output logic [PAGE_W+OFS_W-1:0] base
);
  localparam int ADDR_W = PAGE_W + OFS_W;

  logic [OFS_W-1:0] disp_x;
  logic [OFS_W-1:0] ofs_sum;

  assign disp_x  = {{(OFS_W-DISP_W){field[DISP_W-1]}}, field[DISP_W-1:0]};
  assign ofs_sum = pc[OFS_W-1:0] + disp_x;
  assign base    = rel ? {pc[ADDR_W-1:OFS_W], ofs_sum} : field;
endmodule

// File: rtl/opaddr_ptr_fetch.sv
module opaddr_ptr_fetch
  import opaddr_pkg::*;
#(
  parameter int ADDR_W = opaddr_pkg::PAGE_W + opaddr_pkg::OFS_W,
  parameter int BYTE_W = opaddr_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              ptr_done,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - BYTE_W;

  fetch_st_e         st;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (start) begin
          st     <= F_HI_REQ;
          addr_q <= start_addr;
        end
        F_HI_REQ: if (mem_req_ready) st <= F_HI_RSP;
        F_HI_RSP: if (mem_rsp_valid) begin
          hi_q   <= mem_rsp_data;
          addr_q <= addr_q + ADDR_W'(1);
          st     <= F_LO_REQ;
        end
        F_LO_REQ: if (mem_req_ready) st <= F_LO_RSP;
        F_LO_RSP: if (mem_rsp_valid) st <= F_IDLE;
        default:  st <= F_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == F_HI_REQ) || (st == F_LO_REQ);
  assign mem_req_addr  = addr_q;
  assign busy          = (st != F_IDLE);
  assign ptr_done      = (st == F_LO_RSP) && mem_rsp_valid;
  assign ptr           = {hi_q[HI_W-1:0], mem_rsp_data};

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && $past(busy) && $past(mem_rsp_valid) && !$past(mem_req_valid))
      |-> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(1)));
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int PAGE_W = opaddr_pkg::PAGE_W,
  parameter int OFS_W  = opaddr_pkg::OFS_W,
  parameter int BYTE_W = opaddr_pkg::BYTE_W,
  parameter int DISP_W = opaddr_pkg::DISP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_rel,
  input  logic                    req_ind,
  input  logic [1:0]              req_ix,
  input  logic [PAGE_W+OFS_W-1:0] req_field,
  input  logic [PAGE_W+OFS_W-1:0] req_pc,
  input  logic [BYTE_W-1:0]       req_index,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PAGE_W+OFS_W-1:0] mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [BYTE_W-1:0]       mem_rsp_data,
  output logic                    res_valid,
  output logic [PAGE_W+OFS_W-1:0] res_addr,
  output logic [BYTE_W-1:0]       res_index
);
  localparam int ADDR_W = PAGE_W + OFS_W;

  logic              acc;
  logic              use_ix;
  logic [BYTE_W-1:0] idx_new;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ix_add;
  logic [ADDR_W-1:0] pend_add;
  logic              busy;
  logic              ptr_done;
  logic [ADDR_W-1:0] ptr;

  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;

  opaddr_index_step #(.BYTE_W(BYTE_W)) u_ix (
    .is_abs (!req_rel),
    .op     (req_ix),
    .idx_in (req_index),
    .use_ix (use_ix),
    .idx_out(idx_new)
  );

  opaddr_base #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DISP_W(DISP_W)) u_base (
    .rel  (req_rel),
    .field(req_field),
    .pc   (req_pc),
    .base (base)
  );

  opaddr_ptr_fetch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (acc && req_ind),
    .start_addr   (base),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .busy         (busy),
    .ptr_done     (ptr_done),
    .ptr          (ptr)
  );

  assign ix_add = use_ix ? ADDR_W'(idx_new) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_index <= '0;
      pend_add  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (acc) begin
        res_index <= idx_new;
        if (req_ind) begin
          pend_add <= ix_add;
        end else begin
          res_valid <= 1'b1;
          res_addr  <= base + ix_add;
        end
      end
      if (ptr_done) begin
        res_valid <= 1'b1;
        res_addr  <= ptr + pend_add;
      end
    end
  end

  // R9
  direct_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_ind) |=> res_valid);

  // R6
  rel_index_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_rel) |=> (res_index == $past(req_index)));

  // R2
  rel_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_rel && !req_ind) |=> (res_addr[ADDR_W-1:OFS_W] == $past(req_pc[ADDR_W-1:OFS_W])));

  // R10
  fetch_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R11
  strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);
endmodule

// File: tb/sim_opaddr_unit.sv
module sim_opaddr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rel = 1'b0;
  logic        req_ind = 1'b0;
  logic [1:0]  req_ix = 2'b00;
  logic [14:0] req_field = '0;
  logic [14:0] req_pc = '0;
  logic [7:0]  req_index = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [14:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [7:0]  mem_rsp_data;
  logic        res_valid;
  logic [14:0] res_addr;
  logic [7:0]  res_index;

  always #4 clk = ~clk;

  opaddr_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_rel(req_rel), .req_ind(req_ind), .req_ix(req_ix),
    .req_field(req_field), .req_pc(req_pc), .req_index(req_index),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_index(res_index)
  );

  typedef struct {
    logic [14:0] addr;
    logic [7:0]  idx;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [14:0] rdq[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          stall_mode = 1'b0;
  bit          finished = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(logic [14:0] a);
    return (a[7:0] ^ {a[14:8], 1'b1}) + 8'h5A;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Memory model: single outstanding read, variable latency, optional stall.
  initial begin
    bit          hs_pend = 1'b0;
    int          lat = 0;
    int          nreads = 0;
    int          tick = 0;
    logic [14:0] held = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs_pend) begin
        hs_pend = 1'b0;
        lat = 1 + (nreads % 3);
        nreads++;
      end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mb(held);
        end
      end
      mem_req_ready = stall_mode ? (tick % 3 == 2) : 1'b1;
      tick++;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        hs_pend = 1'b1;
        held = mem_req_addr;
        if (rdq.size() == 0) begin
          check(1'b0, "R7", "unexpected read", int'(mem_req_addr), 0);
        end else begin
          logic [14:0] ea;
          ea = rdq.pop_front();
          // R7 pointer byte order: high at address, low at address+1
          check(mem_req_addr == ea, "R7", "read address", int'(mem_req_addr), int'(ea));
        end
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "extra strobe", int'(res_addr), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_addr == e.addr, e.tag, "address", int'(res_addr), int'(e.addr));
        check(res_index == e.idx, e.tag, "index", int'(res_index), int'(e.idx));
      end
    end
  end

  // Called just after a negedge; returns just after the negedge following acceptance.
  task automatic issue(bit rel, bit ind, logic [1:0] op, logic [14:0] fld,
                       logic [14:0] pc, logic [7:0] idx, string tag);
    logic [7:0]  nidx;
    logic [14:0] base;
    logic [14:0] ptr;
    logic [14:0] add;
    exp_t        e;
    nidx = idx;
    if (!rel && op == 2'b10) nidx = idx + 8'd1;
    if (!rel && op == 2'b11) nidx = idx - 8'd1;
    add = (!rel && op != 2'b00) ? {7'd0, nidx} : 15'd0;
    if (rel) begin
      logic [12:0] o;
      o = pc[12:0] + {{6{fld[6]}}, fld[6:0]};
      base = {pc[14:13], o};
    end else begin
      base = fld;
    end
    if (ind) begin
      ptr = {mb(base)[6:0], mb(base + 15'd1)};
      rdq.push_back(base);
      rdq.push_back(base + 15'd1);
      e.addr = ptr + add;
    end else begin
      e.addr = base + add;
    end
    e.idx = nidx;
    e.tag = tag;
    sb.push_back(e);
    req_rel = rel; req_ind = ind; req_ix = op;
    req_field = fld; req_pc = pc; req_index = idx;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_field = 15'h5555;
    req_index = 8'hC3;
    if (!ind) begin
      // R9 direct result appears the cycle after acceptance
      check(res_valid == 1'b1, "R9", "direct strobe", int'(res_valid), 1);
      // R11 ready in the strobe cycle
      check(req_ready == 1'b1, "R11", "ready at strobe", int'(req_ready), 1);
    end else begin
      // R10 no new request taken while the pointer fetch runs
      check(req_ready == 1'b0, "R10", "ready during fetch", int'(req_ready), 0);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((sb.size() != 0) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(sb.size() == 0, "R9", "results outstanding", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", int'(mem_req_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && mem_req_valid == 1'b0 && req_ready == 1'b1,
          "R1", "state after reset", int'({res_valid, mem_req_valid, req_ready}), 1);

    // R3 absolute
    issue(1'b0, 1'b0, 2'b00, 15'h1234, 15'h0000, 8'h11, "R3");
    // R2 relative: +63, -64, page wrap, upper field bits ignored
    issue(1'b1, 1'b0, 2'b00, 15'h003F, 15'h0100, 8'h22, "R2");
    issue(1'b1, 1'b0, 2'b00, 15'h0040, 15'h0100, 8'h22, "R2");
    issue(1'b1, 1'b0, 2'b00, 15'h0005, 15'h5FFE, 8'h22, "R2");
    issue(1'b1, 1'b0, 2'b00, 15'h7F85, 15'h5FFE, 8'h22, "R2");
    issue(1'b1, 1'b0, 2'b00, 15'h0070, 15'h6005, 8'h22, "R2");
    // R4 plain index, with wrap at the top of the space
    issue(1'b0, 1'b0, 2'b01, 15'h1F00, 15'h0000, 8'h05, "R4");
    issue(1'b0, 1'b0, 2'b01, 15'h7FF0, 15'h0000, 8'h20, "R4");
    // R5 pre-increment / pre-decrement and their wraps
    issue(1'b0, 1'b0, 2'b10, 15'h1F00, 15'h0000, 8'h05, "R5");
    issue(1'b0, 1'b0, 2'b11, 15'h1000, 15'h0000, 8'hA6, "R5");
    issue(1'b0, 1'b0, 2'b10, 15'h2000, 15'h0000, 8'hFF, "R5");
    issue(1'b0, 1'b0, 2'b11, 15'h2000, 15'h0000, 8'h00, "R5");
    // R6 index op ignored in relative form
    issue(1'b1, 1'b0, 2'b10, 15'h0003, 15'h0200, 8'h40, "R6");
    issue(1'b1, 1'b0, 2'b11, 15'h007E, 15'h2200, 8'h00, "R6");
    drain();

    // R7 indirect, absolute and relative, no stall then stall
    issue(1'b0, 1'b1, 2'b00, 15'h0F00, 15'h0000, 8'h01, "R7");
    drain();
    stall_mode = 1'b1;
    issue(1'b1, 1'b1, 2'b00, 15'h007C, 15'h0008, 8'h01, "R7");
    drain();
    issue(1'b0, 1'b1, 2'b00, 15'h1FFF, 15'h0000, 8'h01, "R7");
    // R11 direct request right behind an indirect result
    issue(1'b0, 1'b0, 2'b01, 15'h0300, 15'h0000, 8'h07, "R11");
    drain();
    // R8 indexed indirect: plain, pre-increment, pre-decrement
    issue(1'b0, 1'b1, 2'b01, 15'h0A00, 15'h0000, 8'h10, "R8");
    drain();
    stall_mode = 1'b0;
    issue(1'b0, 1'b1, 2'b10, 15'h0B40, 15'h0000, 8'hFF, "R8");
    drain();
    issue(1'b0, 1'b1, 2'b11, 15'h3C21, 15'h0000, 8'h80, "R8");
    // R11 back-to-back direct chain
    issue(1'b0, 1'b0, 2'b10, 15'h0100, 15'h0000, 8'h01, "R11");
    issue(1'b1, 1'b0, 2'b00, 15'h0010, 15'h4000, 8'h02, "R11");
    issue(1'b0, 1'b0, 2'b00, 15'h7777, 15'h0000, 8'h03, "R11");
    drain();
    check(rdq.size() == 0, "R7", "reads outstanding", rdq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end
endmodule